// File: doc/BRIEF.md
# Point ROM and Parameter RAM Access Port

This block gives a CPU a 16-bit, register-mapped window onto two stores: a small parameter RAM held inside the block, and a large 32-bit-wide point ROM that lives outside it. The CPU selects one of eight word offsets. It sets the RAM address through one offset and then reads or writes the addressed word through another. The ROM pointer is built up 16 bits at a time, and the 32-bit word it selects is read back as two halves.

A status word reports the vertical-blank state of the display. An interrupt request raised by a source pulse is cleared by the CPU through a dedicated acknowledge offset.

Every access is held on the bus until `ready_o` is high. Only ROM reads stall, and only for the single cycle the synchronous ROM needs. A pointer at or beyond a configurable limit reads as all ones instead of wrapping onto valid ROM words.

Top module: `ptrom_param_port`

## Requirements
- R1: Reading offset 0 returns 0x808E while `vblank_i` is low and 0x008E while it is high.
- R2: Offset 1 reads and writes the 16-bit RAM address register. On a write, `be_i[0]` enables bits 7..0 and `be_i[1]` enables bits 15..8, and the bytes that are not enabled keep their value.
- R3: Offset 4 reads or writes the RAM word indexed by the low log2(RAM_DEPTH) bits of the address register, with the same byte-lane rule as R2.
- R4: A write to offset 2 shifts the ROM pointer left by 16 bits and loads the written word into bits 15..0. Byte enables are ignored for this write.
- R5: Any write to offset 3 sets the ROM pointer to zero.
- R6: Reading offset 5 returns bits 31..16 of the ROM word at the pointer, and reading offset 6 returns bits 15..0 of that word.
- R7: When the pointer is greater than or equal to ROM_LIMIT, reads of offset 5 and offset 6 return 0xFFFF.
- R8: A ROM read holds `ready_o` low for exactly one cycle and pulses `rom_rd_o` in that cycle. All other accesses complete with `ready_o` high in their first cycle.
- R9: A high `irq_src_i` sets `irq_o` on the next clock. A write to offset 7 clears it. If both happen in the same cycle, the source wins.
- R10: Reads of offsets 2, 3 and 7 return 0 and change no state. Writes to offsets 0, 5 and 6 change no state.
- R11: After reset, the RAM address is 0, the ROM pointer is 0, `irq_o` is low, and every RAM word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word offset |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte-lane enables for writes |
| rdata_o | output | 16 | Read data, valid when ready_o is high |
| ready_o | output | 1 | Access completes on the clock edge where this is high |
| vblank_i | input | 1 | Display vertical-blank flag |
| irq_src_i | input | 1 | Interrupt set pulse |
| irq_o | output | 1 | Interrupt request |
| rom_addr_o | output | PTR_W | ROM pointer |
| rom_rd_o | output | 1 | ROM read strobe |
| rom_data_i | input | 32 | ROM word, valid one cycle after the strobe |

## Verification
Several shift-in sequences are used for the ROM pointer. One leaves a small in-range value. One pushes a nonzero word into the upper half, so the pointer lands far past the limit. Two land exactly at limit minus one and exactly at the limit, which tells an off-by-one in the compare apart from a correct one.

For the RAM, full-word writes are followed by single-lane writes to each byte in turn, which shows that each lane is separate. The address register is given a high-byte-only write, which shows that the RAM index uses only its low bits.

Unmapped reads and ignored writes are placed between accesses whose results depend on the state those stimuli could have corrupted. Status reads are taken with vblank both low and high.

// File: rtl/ppr_pkg.sv
`timescale 1ns/1ps
package ppr_pkg;
  localparam int DW = 16;
  localparam int NB = DW / 8;

  typedef enum logic [2:0] {
    OFS_STAT   = 3'd0,
    OFS_RADDR  = 3'd1,
    OFS_PSHIFT = 3'd2,
    OFS_PCLR   = 3'd3,
    OFS_RDATA  = 3'd4,
    OFS_PHI    = 3'd5,
    OFS_PLO    = 3'd6,
    OFS_ACK    = 3'd7
  } ofs_e;

  localparam logic [DW-1:0] STAT_BASE  = 16'h008E;
  localparam logic [DW-1:0] STAT_ACTIV = 16'h8000;
endpackage

// File: rtl/ppr_ptr_reg.sv
`timescale 1ns/1ps
module ppr_ptr_reg #(
  parameter int          PTR_W = 32,
  parameter int unsigned LIMIT = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic [15:0]      din_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             oob_o
);
  logic [PTR_W-1:0] ptr_q, ptr_shifted;

  generate
    if (PTR_W > 16) begin : g_wide
      assign ptr_shifted = {ptr_q[PTR_W-17:0], din_i};
    end else begin : g_narrow
      assign ptr_shifted = din_i[PTR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clr_i)   ptr_q <= '0;
    else if (shift_i) ptr_q <= ptr_shifted;
  end

  assign ptr_o = ptr_q;
  assign oob_o = ptr_q >= PTR_W'(LIMIT);
endmodule

// File: rtl/ppr_param_ram.sv
`timescale 1ns/1ps
module ppr_param_ram
  import ppr_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_we_i,
  input  logic          data_we_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] addr_q;
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] idx;

  assign idx = addr_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (addr_we_i) begin
      for (int l = 0; l < NB; l++)
        if (be_i[l]) addr_q[8*l +: 8] <= din_i[8*l +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (data_we_i) begin
      for (int l = 0; l < NB; l++)
        if (be_i[l]) mem_q[idx][8*l +: 8] <= din_i[8*l +: 8];
    end
  end

  assign addr_o  = addr_q;
  assign rdata_o = mem_q[idx];
endmodule

// File: rtl/ppr_irq.sv
`timescale 1ns/1ps
module ppr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  // set beats ack so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ptrom_param_port.sv
`timescale 1ns/1ps
module ptrom_param_port
  import ppr_pkg::*;
#(
  parameter int          PTR_W     = 32,
  parameter int          RAM_DEPTH = 256,
  parameter int unsigned ROM_LIMIT = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [15:0]      wdata_i,
  input  logic [1:0]       be_i,
  output logic [15:0]      rdata_o,
  output logic             ready_o,
  input  logic             vblank_i,
  input  logic             irq_src_i,
  output logic             irq_o,
  output logic [PTR_W-1:0] rom_addr_o,
  output logic             rom_rd_o,
  input  logic [31:0]      rom_data_i
);
  ofs_e          ofs;
  logic          wr, rd_rom, wait_q, oob;
  logic [DW-1:0] ram_addr, ram_rdata;

  assign ofs    = ofs_e'(addr_i);
  assign wr     = sel_i && we_i;
  assign rd_rom = sel_i && !we_i && (ofs == OFS_PHI || ofs == OFS_PLO);

  // one wait cycle covers the synchronous ROM latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= 1'b0;
    else         wait_q <= rd_rom && !wait_q;
  end

  assign ready_o  = !(rd_rom && !wait_q);
  assign rom_rd_o = rd_rom && !wait_q;

  ppr_ptr_reg #(.PTR_W(PTR_W), .LIMIT(ROM_LIMIT)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wr && ofs == OFS_PCLR),
    .shift_i (wr && ofs == OFS_PSHIFT),
    .din_i   (wdata_i),
    .ptr_o   (rom_addr_o),
    .oob_o   (oob)
  );

  ppr_param_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_we_i (wr && ofs == OFS_RADDR),
    .data_we_i (wr && ofs == OFS_RDATA),
    .be_i      (be_i),
    .din_i     (wdata_i),
    .addr_o    (ram_addr),
    .rdata_o   (ram_rdata)
  );

  ppr_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_src_i),
    .ack_i  (wr && ofs == OFS_ACK),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (ofs)
      OFS_STAT:  rdata_o = STAT_BASE | (vblank_i ? '0 : STAT_ACTIV);
      OFS_RADDR: rdata_o = ram_addr;
      OFS_RDATA: rdata_o = ram_rdata;
      OFS_PHI:   rdata_o = oob ? '1 : rom_data_i[31:16];
      OFS_PLO:   rdata_o = oob ? '1 : rom_data_i[15:0];
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ptrom_param_port_chk.sv
`timescale 1ns/1ps
module ptrom_param_port_chk #(
  parameter int          PTR_W     = 32,
  parameter int unsigned ROM_LIMIT = 1000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic [15:0]      wdata_i,
  input logic [15:0]      rdata_o,
  input logic             ready_o,
  input logic             vblank_i,
  input logic             irq_src_i,
  input logic             irq_o,
  input logic [PTR_W-1:0] rom_addr_o
);
  logic rom_rd;
  assign rom_rd = sel_i && !we_i && (addr_i == 3'd5 || addr_i == 3'd6);

  // R1
  status_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && addr_i == 3'd0) |-> rdata_o == (vblank_i ? 16'h008E : 16'h808E));

  // R4
  ptr_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == 3'd2)
      |=> rom_addr_o == {$past(rom_addr_o[PTR_W-17:0]), $past(wdata_i)});

  // R5
  ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == 3'd3) |=> rom_addr_o == '0);

  // R7
  rom_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_rd && ready_o && rom_addr_o >= PTR_W'(ROM_LIMIT)) |-> rdata_o == 16'hFFFF);

  // R8
  rom_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_rd && !ready_o) |=> (ready_o || !sel_i));

  // R8
  no_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !rom_rd) |-> ready_o);

  // R9
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_src_i |=> irq_o);

  // R9
  irq_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == 3'd7 && !irq_src_i) |=> !irq_o);

  // R10
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && (addr_i == 3'd2 || addr_i == 3'd3 || addr_i == 3'd7)) |-> rdata_o == '0);
endmodule

bind ptrom_param_port ptrom_param_port_chk #(.PTR_W(PTR_W), .ROM_LIMIT(ROM_LIMIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .ready_o    (ready_o),
  .vblank_i   (vblank_i),
  .irq_src_i  (irq_src_i),
  .irq_o      (irq_o),
  .rom_addr_o (rom_addr_o)
);

// File: tb/ptrom_param_port_test.sv
`timescale 1ns/1ps
module ptrom_param_port_test;
  localparam int          PTR_W = 32;
  localparam int unsigned LIMIT = 1000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sel_i = 1'b0, we_i = 1'b0;
  logic [2:0]       addr_i = '0;
  logic [15:0]      wdata_i = '0;
  logic [1:0]       be_i = '0;
  logic [15:0]      rdata_o;
  logic             ready_o, vblank_i = 1'b0, irq_src_i = 1'b0, irq_o, rom_rd_o;
  logic [PTR_W-1:0] rom_addr_o;
  logic [31:0]      rom_data_i = '0;

  int vectors = 0, miscompares = 0;
  logic [31:0] mptr = '0;

  always #2 clk_i = ~clk_i;

  ptrom_param_port #(.PTR_W(PTR_W), .RAM_DEPTH(256), .ROM_LIMIT(LIMIT)) uut (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .be_i, .rdata_o, .ready_o,
    .vblank_i, .irq_src_i, .irq_o, .rom_addr_o, .rom_rd_o, .rom_data_i
  );

  function automatic logic [31:0] rom_fn(input logic [9:0] a);
    logic [15:0] x;
    x = {6'd0, a};
    return {16'hC000 | x, 16'h3000 ^ (x * 16'd7)};
  endfunction

  always_ff @(posedge clk_i) if (rom_rd_o) rom_data_i <= rom_fn(rom_addr_o[9:0]);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [2:0] a, input logic [1:0] b,
                     input logic [15:0] d, output logic [15:0] rd, output int waits);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = w; addr_i = a; be_i = b; wdata_i = d; waits = 0;
    #1;
    while (!ready_o) begin @(posedge clk_i); #1; waits++; end
    rd = rdata_o;
    @(posedge clk_i); #1;
    sel_i = 1'b0; we_i = 1'b0;
  endtask

  function automatic logic [15:0] rom_exp(input logic hi);
    logic [31:0] w;
    if (mptr >= LIMIT) return 16'hFFFF;
    w = rom_fn(mptr[9:0]);
    return hi ? w[31:16] : w[15:0];
  endfunction

  // {we, addr, be, wdata, kind(0 none,1 literal,2 rom hi,3 rom lo), expected}
  localparam int NV = 32;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 3'd1, 2'd3, 16'h0005, 2'd0, 16'h0000},
    {1'b1, 3'd4, 2'd3, 16'h1234, 2'd0, 16'h0000},
    {1'b1, 3'd1, 2'd3, 16'h0006, 2'd0, 16'h0000},
    {1'b1, 3'd4, 2'd3, 16'h5555, 2'd0, 16'h0000},
    {1'b1, 3'd4, 2'd1, 16'hAAFF, 2'd0, 16'h0000},
    {1'b1, 3'd4, 2'd2, 16'h77AA, 2'd0, 16'h0000},
    {1'b0, 3'd4, 2'd0, 16'h0000, 2'd1, 16'h77FF},
    {1'b1, 3'd1, 2'd3, 16'h0005, 2'd0, 16'h0000},
    {1'b0, 3'd4, 2'd0, 16'h0000, 2'd1, 16'h1234},
    {1'b1, 3'd1, 2'd2, 16'h03FF, 2'd0, 16'h0000},
    {1'b0, 3'd1, 2'd0, 16'h0000, 2'd1, 16'h0305},
    {1'b0, 3'd4, 2'd0, 16'h0000, 2'd1, 16'h1234},
    {1'b1, 3'd3, 2'd0, 16'h0000, 2'd0, 16'h0000},
    {1'b1, 3'd2, 2'd0, 16'h0000, 2'd0, 16'h0000},
    {1'b1, 3'd2, 2'd0, 16'h0010, 2'd0, 16'h0000},
    {1'b0, 3'd5, 2'd0, 16'h0000, 2'd2, 16'h0000},
    {1'b0, 3'd6, 2'd0, 16'h0000, 2'd3, 16'h0000},
    {1'b1, 3'd2, 2'd3, 16'h0001, 2'd0, 16'h0000},
    {1'b0, 3'd5, 2'd0, 16'h0000, 2'd1, 16'hFFFF},
    {1'b0, 3'd6, 2'd0, 16'h0000, 2'd1, 16'hFFFF},
    {1'b1, 3'd3, 2'd0, 16'hBEEF, 2'd0, 16'h0000},
    {1'b0, 3'd5, 2'd0, 16'h0000, 2'd2, 16'h0000},
    {1'b1, 3'd2, 2'd0, 16'h03E7, 2'd0, 16'h0000},
    {1'b0, 3'd3, 2'd0, 16'h0000, 2'd1, 16'h0000},
    {1'b0, 3'd6, 2'd0, 16'h0000, 2'd3, 16'h0000},
    {1'b1, 3'd3, 2'd0, 16'h0000, 2'd0, 16'h0000},
    {1'b1, 3'd2, 2'd0, 16'h03E8, 2'd0, 16'h0000},
    {1'b0, 3'd5, 2'd0, 16'h0000, 2'd1, 16'hFFFF},
    {1'b1, 3'd0, 2'd3, 16'hFFFF, 2'd0, 16'h0000},
    {1'b1, 3'd5, 2'd3, 16'h0000, 2'd0, 16'h0000},
    {1'b1, 3'd6, 2'd3, 16'h0000, 2'd0, 16'h0000},
    {1'b0, 3'd1, 2'd0, 16'h0000, 2'd1, 16'h0305}
  };

  initial begin
    #(4 * 50000);
    miscompares++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int w;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R11 reset state
    #1;
    check("R11 irq", {15'd0, irq_o}, 16'h0);
    check("R11 ptr", rom_addr_o[15:0], 16'h0);
    bus(1'b0, 3'd1, 2'd0, 16'h0, rd, w); check("R11 ram addr", rd, 16'h0);
    bus(1'b0, 3'd4, 2'd0, 16'h0, rd, w); check("R11 ram word", rd, 16'h0);

    // R2 R3 R4 R5 R6 R7 R10 table
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      bus(v[39], v[38:36], v[35:34], v[33:18], rd, w);
      if (v[39] && v[38:36] == 3'd2) mptr = {mptr[15:0], v[33:18]};
      if (v[39] && v[38:36] == 3'd3) mptr = '0;
      case (v[17:16])
        2'd1: check($sformatf("R2/R3/R7/R10 vec%0d", i), rd, v[15:0]);
        2'd2: check($sformatf("R6 hi vec%0d", i), rd, rom_exp(1'b1));
        2'd3: check($sformatf("R6 lo vec%0d", i), rd, rom_exp(1'b0));
        default: ;
      endcase
    end

    // R1 status under both vblank levels
    vblank_i = 1'b0;
    bus(1'b0, 3'd0, 2'd0, 16'h0, rd, w); check("R1 active", rd, 16'h808E);
    vblank_i = 1'b1;
    bus(1'b0, 3'd0, 2'd0, 16'h0, rd, w); check("R1 vblank", rd, 16'h008E);

    // R8 wait cycles
    bus(1'b1, 3'd3, 2'd0, 16'h0, rd, w);
    mptr = '0;
    bus(1'b0, 3'd6, 2'd0, 16'h0, rd, w);
    check("R8 rom waits", 16'(w), 16'd1);
    check("R6 lo at 0", rd, rom_exp(1'b0));
    bus(1'b0, 3'd4, 2'd0, 16'h0, rd, w);
    check("R8 ram waits", 16'(w), 16'd0);

    // R9 set, unmapped read leaves it, ack clears, set wins over ack
    @(negedge clk_i); irq_src_i = 1'b1;
    @(negedge clk_i); irq_src_i = 1'b0;
    check("R9 set", {15'd0, irq_o}, 16'h1);
    bus(1'b0, 3'd7, 2'd0, 16'h0, rd, w);
    check("R10 read ack ofs", rd, 16'h0);
    check("R10 irq kept", {15'd0, irq_o}, 16'h1);
    bus(1'b1, 3'd7, 2'd0, 16'h0, rd, w);
    check("R9 ack", {15'd0, irq_o}, 16'h0);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b1; addr_i = 3'd7; irq_src_i = 1'b1;
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0; irq_src_i = 1'b0;
    check("R9 set wins", {15'd0, irq_o}, 16'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule